// File: doc/BRIEF.md
# USB Controller Configuration and Interrupt Register Bank

This block is a 32-bit register bank on a simple APB-style bus. It holds the static settings a USB host or device controller reads at run time, and it has a small two-source interrupt unit. The settings are a bus-filter bypass nibble, five port strap bits, a 6-bit frame-length adjust value, an endianness select, a coherency select, a bus-master enable and an error-response enable. Each setting drives an output pin of the block directly.

The interrupt unit records two events in sticky status bits. Bit 0 is an address-decode error, raised when the bus accesses an offset that has no register. Bit 1 is a host system error, raised by a one-cycle pulse on `host_err_i`. Software cannot write the mask directly. It can only clear mask bits through the unmask command word and set them through the mask command word. The single level output `irq_o` is high while any status bit is set and its mask bit is clear.

A two-state bus phase machine controls every transfer. State IDLE waits for a setup phase (`psel` high with `penable` low) and then moves to ACCESS. State ACCESS drives `pready` high and commits the transfer if `psel` and `penable` are both high. It always returns to IDLE on the next edge.

Top module: `usbcfg_regbank`

## Requirements
- R1: After reset, every configuration output is 0, the status word reads 0, the mask word (offset 0x68) reads 0x3 and `irq_o` is low.
- R2: Offset 0x30 holds the filter-bypass field in bits [3:0]. This field drives `flt_bypass_o`, and the other bits of the word read 0.
- R3: Offset 0x34 holds the five port straps in bits [4:0]: bit 0 hub permanently attached, bit 1 power control present, bit 2 message-signalled interrupts on, bit 3 PCI command-register write, bit 4 BAR write. These bits drive `port_straps_o[4:0]` with the same positions.
- R4: Offset 0x38 holds the frame-length adjust value in bits [5:0], which drives `frame_adj_o`.
- R5: Bit 0 of each of the following offsets is a single control bit: 0x40 drives `big_endian_o`, 0x44 drives `coherent_o`, 0x48 drives `bus_master_o`, and 0x60 is the error-response enable, which has no pin and is read back only.
- R6: Offset 0x64 is the status word: bit 0 is the address-decode error and bit 1 is the host system error. A bit is set by its event and cleared by writing 1 to it. Writing 0 leaves it unchanged. If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: `irq_o` equals the OR over the bits of (status AND NOT mask). It follows any change of status or mask in the cycle after the committing edge.
- R8: Writing 1s to offset 0x6C clears the matching mask bits, and writing 1s to 0x70 sets them. Both offsets read 0. Writing to the mask word at 0x68 has no effect.
- R9: A transfer is erroneous when `paddr[1:0]` is not 0 or when the offset has no register. Such a transfer reads 0, changes no configuration register and sets status bit 0.
- R10: `pslverr` is high in the access phase of an erroneous transfer only when the error-response enable is 1. Otherwise it is low.
- R11: `pready` is low in the setup phase and high in the access phase that follows it. Each setup/access pair commits exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer-complete indicator |
| pslverr | output | 1 | Error response |
| host_err_i | input | 1 | One-cycle host system error event |
| flt_bypass_o | output | 4 | Bus-filter bypass setting |
| port_straps_o | output | 5 | Port strap settings |
| frame_adj_o | output | 6 | Frame-length adjust value |
| big_endian_o | output | 1 | Endianness select |
| coherent_o | output | 1 | Coherency select |
| bus_master_o | output | 1 | Bus-master enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the interrupt corner cases: an event that is masked must not raise `irq_o`, and a write-1-clear that meets an event in the same cycle must leave the bit set. A design that let clear win would lose that event without signalling it. Two further checks catch a writable mask. Writing 0 to offset 0x68 must leave the sources masked, and the command words must read 0. Erroneous transfers are tried both misaligned and unmapped, with the error response both off and on. A design that let a misaligned write through would corrupt the filter field, and one that ignored the enable would raise a bus error at the wrong time.

// File: rtl/usbcfg_pkg.sv
package usbcfg_pkg;
    localparam int DATA_W = 32;
    localparam int N_SRC  = 2;

    localparam logic [7:0] OFS_FILTER = 8'h30;
    localparam logic [7:0] OFS_PORT   = 8'h34;
    localparam logic [7:0] OFS_FRAME  = 8'h38;
    localparam logic [7:0] OFS_ENDIAN = 8'h40;
    localparam logic [7:0] OFS_COHER  = 8'h44;
    localparam logic [7:0] OFS_BME    = 8'h48;
    localparam logic [7:0] OFS_ERRCTL = 8'h60;
    localparam logic [7:0] OFS_STATUS = 8'h64;
    localparam logic [7:0] OFS_MASK   = 8'h68;
    localparam logic [7:0] OFS_UNMASK = 8'h6C;
    localparam logic [7:0] OFS_DOMASK = 8'h70;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } phase_t;

    typedef struct packed {
        logic [3:0] bypass;
        logic [4:0] straps;
        logic [5:0] fadj;
        logic       endian;
        logic       coher;
        logic       bme;
        logic       errresp;
    } cfg_t;
endpackage

// File: rtl/usbcfg_apb_fsm.sv
module usbcfg_apb_fsm
    import usbcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic pready,
    output logic commit
);
    phase_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (psel && !penable) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pready = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACCESS: begin
                pready = 1'b1;
                commit = psel && penable;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/usbcfg_cfg_regs.sv
module usbcfg_cfg_regs
    import usbcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [N_SRC-1:0]  status,
    input  logic [N_SRC-1:0]  mask,
    output logic [DATA_W-1:0] rdata,
    output logic              bad,
    output logic              wr_w1c,
    output logic              wr_unmask,
    output logic              wr_domask,
    output cfg_t              cfg
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0] ofs;
    logic       in_win;
    logic       hit;
    logic       wr_ok;

    assign ofs    = paddr[7:0];
    assign in_win = (paddr[ADDR_W-1:8] == {HI_W{1'b0}});

    always_comb begin
        unique case (ofs)
            OFS_FILTER, OFS_PORT, OFS_FRAME, OFS_ENDIAN, OFS_COHER, OFS_BME,
            OFS_ERRCTL, OFS_STATUS, OFS_MASK, OFS_UNMASK, OFS_DOMASK: hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end

    assign bad   = !in_win || !hit || (paddr[1:0] != 2'b00);
    assign wr_ok = commit && pwrite && !bad;

    assign wr_w1c    = wr_ok && (ofs == OFS_STATUS);
    assign wr_unmask = wr_ok && (ofs == OFS_UNMASK);
    assign wr_domask = wr_ok && (ofs == OFS_DOMASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ok) begin
            unique case (ofs)
                OFS_FILTER: cfg.bypass  <= pwdata[3:0];
                OFS_PORT:   cfg.straps  <= pwdata[4:0];
                OFS_FRAME:  cfg.fadj    <= pwdata[5:0];
                OFS_ENDIAN: cfg.endian  <= pwdata[0];
                OFS_COHER:  cfg.coher   <= pwdata[0];
                OFS_BME:    cfg.bme     <= pwdata[0];
                OFS_ERRCTL: cfg.errresp <= pwdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (!bad) begin
            unique case (ofs)
                OFS_FILTER: rdata[3:0]       = cfg.bypass;
                OFS_PORT:   rdata[4:0]       = cfg.straps;
                OFS_FRAME:  rdata[5:0]       = cfg.fadj;
                OFS_ENDIAN: rdata[0]         = cfg.endian;
                OFS_COHER:  rdata[0]         = cfg.coher;
                OFS_BME:    rdata[0]         = cfg.bme;
                OFS_ERRCTL: rdata[0]         = cfg.errresp;
                OFS_STATUS: rdata[N_SRC-1:0] = status;
                OFS_MASK:   rdata[N_SRC-1:0] = mask;
                default:    rdata = '0;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^pwdata[DATA_W-1:6];
endmodule

// File: rtl/usbcfg_irq_unit.sv
module usbcfg_irq_unit
    import usbcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             w1c_i,
    input  logic             unmask_i,
    input  logic             domask_i,
    input  logic [N_SRC-1:0] wdata_i,
    output logic [N_SRC-1:0] status_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             irq_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      status_o[g] <= 1'b0;
            else if (set_i[g])               status_o[g] <= 1'b1;
            else if (w1c_i && wdata_i[g])    status_o[g] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mask_o[g] <= 1'b1;
            else if (unmask_i && wdata_i[g]) mask_o[g] <= 1'b0;
            else if (domask_i && wdata_i[g]) mask_o[g] <= 1'b1;
        end
    end

    assign irq_o = |(status_o & ~mask_o);
endmodule

// File: rtl/usbcfg_regbank.sv
module usbcfg_regbank
    import usbcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              host_err_i,
    output logic [3:0]        flt_bypass_o,
    output logic [4:0]        port_straps_o,
    output logic [5:0]        frame_adj_o,
    output logic              big_endian_o,
    output logic              coherent_o,
    output logic              bus_master_o,
    output logic              irq_o
);
    logic             commit;
    logic             bad;
    logic             wr_w1c, wr_unmask, wr_domask;
    logic [N_SRC-1:0] status, mask, set_vec;
    cfg_t             cfg;

    usbcfg_apb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pready  (pready),
        .commit  (commit)
    );

    usbcfg_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .status    (status),
        .mask      (mask),
        .rdata     (prdata),
        .bad       (bad),
        .wr_w1c    (wr_w1c),
        .wr_unmask (wr_unmask),
        .wr_domask (wr_domask),
        .cfg       (cfg)
    );

    assign set_vec = {host_err_i, commit && bad};

    usbcfg_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .w1c_i    (wr_w1c),
        .unmask_i (wr_unmask),
        .domask_i (wr_domask),
        .wdata_i  (pwdata[N_SRC-1:0]),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    assign pslverr       = pready && bad && cfg.errresp;
    assign flt_bypass_o  = cfg.bypass;
    assign port_straps_o = cfg.straps;
    assign frame_adj_o   = cfg.fadj;
    assign big_endian_o  = cfg.endian;
    assign coherent_o    = cfg.coher;
    assign bus_master_o  = cfg.bme;
endmodule

// File: rtl/usbcfg_regbank_chk.sv
module usbcfg_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic              pready,
    input logic              pslverr,
    input logic              commit,
    input logic              host_err_i,
    input logic [1:0]        status,
    input logic [1:0]        mask
);
    logic wr_cmd;
    assign wr_cmd = commit && pwrite && (paddr[1:0] == 2'b00)
                    && (paddr[ADDR_W-1:8] == '0);

    // R11: ready only in an access phase
    a_r11_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> (psel && penable));

    // R11: no two commits back to back
    a_r11_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R10: error response only with ready
    a_r10_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready);

    // R6: host event is recorded
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_i |=> status[1]);

    // R6: write-1-clear without a competing event
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && paddr[7:0] == 8'h64 && pwdata[1] && !host_err_i) |=> !status[1]);

    // R8: mask command sets the bit
    a_r8_domask_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && paddr[7:0] == 8'h70 && pwdata[0]) |=> mask[0]);

    // R8: unmask command clears the bit
    a_r8_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && paddr[7:0] == 8'h6C && pwdata[1]) |=> !mask[1]);
endmodule

bind usbcfg_regbank usbcfg_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .pready     (pready),
    .pslverr    (pslverr),
    .commit     (commit),
    .host_err_i (host_err_i),
    .status     (status),
    .mask       (mask)
);

// File: tb/usbcfg_regbank_tb.sv
module usbcfg_regbank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready, pslverr;
    logic              host_err = 1'b0;
    logic [3:0]        flt_bypass;
    logic [4:0]        port_straps;
    logic [5:0]        frame_adj;
    logic              big_endian, coherent, bus_master, irq;

    int vectors = 0;
    int miscompares = 0;
    bit compare_on = 1'b0;

    usbcfg_regbank #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .host_err_i(host_err), .flt_bypass_o(flt_bypass),
        .port_straps_o(port_straps), .frame_adj_o(frame_adj),
        .big_endian_o(big_endian), .coherent_o(coherent),
        .bus_master_o(bus_master), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int m_byp, m_port, m_fadj, m_end, m_coh, m_bme, m_err, m_stat, m_mask;

    function automatic bit m_bad(int a);
        if ((a % 4) != 0) return 1'b1;
        case (a)
            'h30, 'h34, 'h38, 'h40, 'h44, 'h48, 'h60, 'h64, 'h68, 'h6C, 'h70: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int m_read(int a);
        if (m_bad(a)) return 0;
        case (a)
            'h30: return m_byp;
            'h34: return m_port;
            'h38: return m_fadj;
            'h40: return m_end;
            'h44: return m_coh;
            'h48: return m_bme;
            'h60: return m_err;
            'h64: return m_stat;
            'h68: return m_mask;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_byp = 0; m_port = 0; m_fadj = 0; m_end = 0; m_coh = 0;
            m_bme = 0; m_err = 0; m_stat = 0; m_mask = 3;
        end else begin
            int a, d, setv, clrv;
            a = int'(paddr); d = int'(pwdata);
            setv = host_err ? 2 : 0;
            clrv = 0;
            if (psel && penable) begin
                if (m_bad(a)) setv = setv | 1;
                else if (pwrite) begin
                    case (a)
                        'h30: m_byp  = d & 'hF;
                        'h34: m_port = d & 'h1F;
                        'h38: m_fadj = d & 'h3F;
                        'h40: m_end  = d & 1;
                        'h44: m_coh  = d & 1;
                        'h48: m_bme  = d & 1;
                        'h60: m_err  = d & 1;
                        'h64: clrv   = d & 3;
                        'h6C: m_mask = m_mask & ~(d & 3);
                        'h70: m_mask = m_mask | (d & 3);
                        default: ;
                    endcase
                end
            end
            m_stat = (m_stat & ~clrv) | setv;
        end
    end

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (compare_on && rst_n) begin
            chk("R2 flt_bypass_o", int'(flt_bypass), m_byp);
            chk("R3 port_straps_o", int'(port_straps), m_port);
            chk("R4 frame_adj_o", int'(frame_adj), m_fadj);
            chk("R5 big_endian_o", int'(big_endian), m_end);
            chk("R5 coherent_o", int'(coherent), m_coh);
            chk("R5 bus_master_o", int'(bus_master), m_bme);
            chk("R7 irq_o", int'(irq), ((m_stat & ~m_mask) != 0) ? 1 : 0);
        end
    end

    task automatic xfer(bit wr, int a, int d, bit pulse_host, output int rd);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr;
        paddr = ADDR_W'(a); pwdata = d;
        #1;
        chk("R11 pready low in setup", int'(pready), 0);
        @(negedge clk);
        penable = 1'b1;
        if (pulse_host) host_err = 1'b1;
        #1;
        chk("R11 pready high in access", int'(pready), 1);
        chk("R10 pslverr", int'(pslverr), (m_bad(a) && m_err == 1) ? 1 : 0);
        if (!wr) chk("R9 read data", int'(prdata), m_read(a));
        rd = int'(prdata);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; host_err = 1'b0;
    endtask

    task automatic wr(int a, int d);
        int r;
        xfer(1'b1, a, d, 1'b0, r);
    endtask

    task automatic rd_exp(string tag, int a, int exp);
        int r;
        xfer(1'b0, a, 0, 1'b0, r);
        chk(tag, r, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_on = 1'b1;
        // R1 reset values
        rd_exp("R1 mask after reset", 'h68, 3);
        rd_exp("R1 status after reset", 'h64, 0);
        chk("R1 irq after reset", int'(irq), 0);
        // R2
        wr('h30, 'hFFFF_FFFF);
        rd_exp("R2 bypass readback", 'h30, 'hF);
        // R3
        wr('h34, 'h15);  rd_exp("R3 straps 0x15", 'h34, 'h15);
        wr('h34, 'hFFFF_FFEA); rd_exp("R3 straps 0x0A", 'h34, 'h0A);
        // R4
        wr('h38, 'h3F);  rd_exp("R4 fadj 0x3F", 'h38, 'h3F);
        wr('h38, 'h2A);  rd_exp("R4 fadj 0x2A", 'h38, 'h2A);
        // R5
        wr('h40, 1); wr('h44, 1); wr('h48, 3);
        rd_exp("R5 endian", 'h40, 1);
        rd_exp("R5 bme", 'h48, 1);
        // R6 / R7: masked event
        @(negedge clk); host_err = 1'b1; @(negedge clk); host_err = 1'b0;
        rd_exp("R6 host event sets bit1", 'h64, 2);
        chk("R7 masked event keeps irq low", int'(irq), 0);
        // R8 unmask bit1
        wr('h6C, 2);
        rd_exp("R8 unmask read zero", 'h6C, 0);
        rd_exp("R8 mask after unmask", 'h68, 1);
        chk("R7 irq raised after unmask", int'(irq), 1);
        // R6 write 0 no effect, then clear
        wr('h64, 0);
        rd_exp("R6 write zero keeps status", 'h64, 2);
        wr('h64, 2);
        rd_exp("R6 w1c clears", 'h64, 0);
        chk("R7 irq low after clear", int'(irq), 0);
        // R8 direct mask write ignored
        wr('h68, 0);
        rd_exp("R8 mask not writable", 'h68, 1);
        // R9 / R10 bad read with error response off
        rd_exp("R9 unmapped read zero", 'h7C, 0);
        rd_exp("R9 decode error recorded", 'h64, 1);
        wr('h64, 1);
        // R10 error response on, misaligned write
        wr('h60, 1);
        wr('h31, 0);
        rd_exp("R9 misaligned write ignored", 'h30, 'hF);
        rd_exp("R9 decode error again", 'h64, 1);
        // R8 unmask bit0 -> irq, then mask both
        wr('h6C, 1);
        chk("R7 decode error irq", int'(irq), 1);
        wr('h70, 3);
        rd_exp("R8 mask set by command", 'h68, 3);
        chk("R8 irq low after mask", int'(irq), 0);
        rd_exp("R8 domask read zero", 'h70, 0);
        // R6 event meets clear in same cycle
        wr('h6C, 3);
        wr('h64, 3);
        xfer(1'b1, 'h64, 2, 1'b1, r);
        rd_exp("R6 set wins over clear", 'h64, 2);
        // R11 back-to-back reads
        rd_exp("R11 back-to-back read 1", 'h38, 'h2A);
        rd_exp("R11 back-to-back read 2", 'h34, 'h0A);
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule